// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits between two independent memory ports, left and right, and the write strobes of a shared word array. Each port presents an active-low enable and a word address. When both ports are enabled at the same word, the block picks one winner. It then drives an active-low busy flag to the other port and suppresses that port's write strobe, so the losing write never reaches the array. The direction of either access plays no part in the decision.

A mode input selects how the block behaves. In master mode it arbitrates and drives the busy flags. In slave mode it does no arbitration of its own: it takes a busy level per port from outside, for example from a master instance that sits beside it in a wider word, and uses that level only to block writes. All inputs are sampled on the rising clock edge. Every output is registered and reflects the inputs sampled at the previous edge.

Top module: `dp_collide_arb`

## Requirements
- R1: A collision exists only when both enables are low (0) and the two addresses are equal. With no collision sampled, and in master mode, both busy outputs are high (1) after the edge.
- R2: When a collision starts, the winner is the port that already presented the same enabled address at the previous sample. The other port, which presented its key only now, has its busy output driven low.
- R3: When both ports present their colliding key for the first time in the same sample, the left port wins and the right busy output goes low.
- R4: The two busy outputs are never low at the same time.
- R5: The read/write direction of either port has no effect on which busy output goes low.
- R6: In master mode, a port's inhibit output equals the inverse of its busy output. A write request on an inhibited port is dropped, so its gated write is 0.
- R7: In slave mode, both busy outputs stay high. Each port's inhibit is the inverse of its sampled busy input: input 0 blocks writes, input 1 allows them.
- R8: Busy is released at the edge where the address match ends or either enable is high.
- R9: While a collision continues without a break, the winner is held, even if the keys would now decide it the other way.
- R10: Busy, inhibit and gated write all change one clock after their inputs are sampled. The gated write is the sampled write request ANDed with the inverse of the inhibit for the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = take busy from outside |
| l_en_n | input | 1 | Left port enable, active low |
| l_addr | input | 14 | Left port word address |
| l_wr | input | 1 | Left port write request, active high |
| l_busy_in_n | input | 1 | Left busy input used in slave mode, active low |
| r_en_n | input | 1 | Right port enable, active low |
| r_addr | input | 14 | Right port word address |
| r_wr | input | 1 | Right port write request, active high |
| r_busy_in_n | input | 1 | Right busy input used in slave mode, active low |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_busy_out_n | output | 1 | Right busy flag, active low |
| l_inhibit | output | 1 | Left write inhibit, active high |
| r_inhibit | output | 1 | Right write inhibit, active high |
| l_wr_gated | output | 1 | Left write strobe after gating |
| r_wr_gated | output | 1 | Right write strobe after gating |

## Verification
The bench steers the addresses into a tiny window so that collisions occur often, and it drives both ports into a collision in the same cycle. A design with no tie-break would pull both busy flags low, or leave both high. Directed runs start a collision with one port already standing on the address and then hold it while the keys become symmetric. A design that re-decides each cycle would move busy to the other port in the middle of a collision. A design that looked at write direction, or that let an inhibited write through, would show a wrong busy flag or a stray gated strobe. Slave-mode runs toggle the busy inputs on their own, so an inhibit taken from the internal winner instead of the pin is caught.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_L    = 2'd1,
    WIN_R    = 2'd2
  } win_e;

  // Decide a fresh collision: the port whose key was already standing wins,
  // a simultaneous start goes to the left port.
  function automatic win_e pick_winner(input logic l_fresh, input logic r_fresh);
    if (!l_fresh && r_fresh) return WIN_L;
    if (l_fresh && !r_fresh) return WIN_R;
    return WIN_L;
  endfunction
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [AW-1:0] addr,
  output logic          fresh
);
  logic          prev_act_q;
  logic [AW-1:0] prev_addr_q;

  function automatic logic key_changed(input logic was_act, input logic [AW-1:0] was_addr,
                                       input logic [AW-1:0] now_addr);
    return !was_act || (was_addr != now_addr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_act_q  <= !en_n;
      prev_addr_q <= addr;
    end
  end

  assign fresh = key_changed(prev_act_q, prev_addr_q, addr);
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic hit,
  input  logic l_fresh,
  input  logic r_fresh,
  output win_e win_d,
  output win_e win_q
);
  always_comb begin
    if (!master_mode || !hit)  win_d = WIN_NONE;
    else if (win_q != WIN_NONE) win_d = win_q;
    else                        win_d = pick_winner(l_fresh, r_fresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= WIN_NONE;
    else        win_q <= win_d;
  end

  // R9
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_L && hit && master_mode) |=> (win_q == WIN_L));
  // R9
  hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_R && hit && master_mode) |=> (win_q == WIN_R));
  // R3
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_NONE && hit && master_mode && l_fresh && r_fresh) |=> (win_q == WIN_L));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> (win_q == WIN_NONE));
endmodule

// File: rtl/dpa_gate.sv
module dpa_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic lost,
  input  logic busy_in_n,
  input  logic wr,
  output logic busy_out_n,
  output logic inhibit,
  output logic wr_gated
);
  logic inh_d;

  assign inh_d = master_mode ? lost : !busy_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_out_n <= 1'b1;
      inhibit    <= 1'b0;
      wr_gated   <= 1'b0;
    end else begin
      busy_out_n <= !(master_mode && lost);
      inhibit    <= inh_d;
      wr_gated   <= wr && !inh_d;
    end
  end

  // R6
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !wr_gated);
  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode) |=> busy_out_n);
  // R7
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode) |=> (inhibit == !$past(busy_in_n)));
  // R10
  pass_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !master_mode && busy_in_n) |=> wr_gated);
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
  import dpa_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          l_busy_in_n,
  input  logic          r_en_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr,
  input  logic          r_busy_in_n,
  output logic          l_busy_out_n,
  output logic          r_busy_out_n,
  output logic          l_inhibit,
  output logic          r_inhibit,
  output logic          l_wr_gated,
  output logic          r_wr_gated
);
  localparam int NPORT = 2;

  logic hit;
  logic l_fresh, r_fresh;
  win_e win_d, win_q;

  function automatic logic same_word(input logic a_en_n, input logic b_en_n,
                                     input logic [AW-1:0] a, input logic [AW-1:0] b);
    return !a_en_n && !b_en_n && (a == b);
  endfunction

  assign hit = same_word(l_en_n, r_en_n, l_addr, r_addr);

  dpa_port_track #(.AW(AW)) u_trk_l (
    .clk(clk), .rst_n(rst_n), .en_n(l_en_n), .addr(l_addr), .fresh(l_fresh));
  dpa_port_track #(.AW(AW)) u_trk_r (
    .clk(clk), .rst_n(rst_n), .en_n(r_en_n), .addr(r_addr), .fresh(r_fresh));

  dpa_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .hit(hit),
    .l_fresh(l_fresh), .r_fresh(r_fresh), .win_d(win_d), .win_q(win_q));

  logic [NPORT-1:0] lost_v, bin_v, wr_v, bout_v, inh_v, wg_v;
  assign lost_v = {win_d == WIN_L, win_d == WIN_R};
  assign bin_v  = {r_busy_in_n, l_busy_in_n};
  assign wr_v   = {r_wr, l_wr};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_gate u_gate (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .lost(lost_v[p]), .busy_in_n(bin_v[p]), .wr(wr_v[p]),
      .busy_out_n(bout_v[p]), .inhibit(inh_v[p]), .wr_gated(wg_v[p]));
  end

  assign l_busy_out_n = bout_v[0];
  assign r_busy_out_n = bout_v[1];
  assign l_inhibit    = inh_v[0];
  assign r_inhibit    = inh_v[1];
  assign l_wr_gated   = wg_v[0];
  assign r_wr_gated   = wg_v[1];

  // R4
  never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_out_n && !r_busy_out_n));
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> (l_busy_out_n && r_busy_out_n));
  // R6
  master_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |=> (l_inhibit == !l_busy_out_n && r_inhibit == !r_busy_out_n));
  // R2
  standing_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && win_q == WIN_NONE && !l_fresh && r_fresh) |=> !r_busy_out_n);
endmodule

// File: tb/dp_collide_arb_bench.sv
`timescale 1ns/100ps
module dp_collide_arb_bench;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en_n = 1'b1, r_en_n = 1'b1, l_wr = 1'b0, r_wr = 1'b0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_out_n, r_busy_out_n, l_inhibit, r_inhibit, l_wr_gated, r_wr_gated;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  int ewin = 0;  // 0 none, 1 left, 2 right
  logic m_lpa = 0, m_rpa = 0;
  logic [AW-1:0] m_la = '0, m_ra = '0;
  logic e_lb = 1, e_rb = 1, e_li = 0, e_ri = 0, e_lg = 0, e_rg = 0;
  string pend_tag = "R10";

  always #2.5 clk = ~clk;

  dp_collide_arb #(.AW(AW)) u_dp_collide_arb (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en_n(l_en_n), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in_n(l_busy_in_n),
    .r_en_n(r_en_n), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
    .l_inhibit(l_inhibit), .r_inhibit(r_inhibit),
    .l_wr_gated(l_wr_gated), .r_wr_gated(r_wr_gated));

  task automatic cmp(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    cmp(pend_tag, "l_busy_out_n", l_busy_out_n, e_lb);
    cmp(pend_tag, "r_busy_out_n", r_busy_out_n, e_rb);
    cmp(pend_tag, "l_inhibit", l_inhibit, e_li);
    cmp(pend_tag, "r_inhibit", r_inhibit, e_ri);
    cmp(pend_tag, "l_wr_gated", l_wr_gated, e_lg);
    cmp(pend_tag, "r_wr_gated", r_wr_gated, e_rg);
    // R4: both flags low at once is never legal
    cmp("R4", "both busy low", !(!l_busy_out_n && !r_busy_out_n), 1'b1);
  endtask

  // Expected outputs after the edge that samples the current inputs.
  task automatic model_step();
    logic hit, lnew, rnew;
    hit  = !l_en_n && !r_en_n && (l_addr == r_addr);
    lnew = !m_lpa || (m_la != l_addr);
    rnew = !m_rpa || (m_ra != r_addr);
    if (master_mode && hit) begin
      if (ewin == 0) begin
        if (!lnew && rnew) ewin = 1;
        else if (lnew && !rnew) ewin = 2;
        else ewin = 1;
      end
    end else ewin = 0;
    e_lb = !(master_mode && ewin == 2);
    e_rb = !(master_mode && ewin == 1);
    e_li = master_mode ? (ewin == 2) : !l_busy_in_n;
    e_ri = master_mode ? (ewin == 1) : !r_busy_in_n;
    e_lg = l_wr && !e_li;
    e_rg = r_wr && !e_ri;
    m_lpa = !l_en_n; m_la = l_addr;
    m_rpa = !r_en_n; m_ra = r_addr;
  endtask

  task automatic step(string tag, logic mm, logic len, logic [AW-1:0] la, logic lw, logic lbi,
                      logic ren, logic [AW-1:0] ra, logic rw, logic rbi);
    @(negedge clk);
    check_outputs();
    master_mode = mm;
    l_en_n = len; l_addr = la; l_wr = lw; l_busy_in_n = lbi;
    r_en_n = ren; r_addr = ra; r_wr = rw; r_busy_in_n = rbi;
    model_step();
    pend_tag = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    cmp("R1", "reset l_busy", l_busy_out_n, 1'b1);
    cmp("R1", "reset r_busy", r_busy_out_n, 1'b1);
    cmp("R10", "reset l_gated", l_wr_gated, 1'b0);
    cmp("R10", "reset r_gated", r_wr_gated, 1'b0);
    rst_n = 1'b1;

    // R3: both keys appear together, left wins; R6 right write dropped
    step("R3", 1, 0, 14'h0123, 1, 1, 0, 14'h0123, 1, 1);
    // R9: both keys now standing, winner stays left
    step("R9", 1, 0, 14'h0123, 0, 1, 0, 14'h0123, 1, 1);
    // R8: left enable high releases
    step("R8", 1, 1, 14'h0123, 0, 1, 0, 14'h0123, 1, 1);
    // R2: right standing, left arrives -> left busy
    step("R2", 1, 0, 14'h0123, 1, 1, 0, 14'h0123, 0, 1);
    // R9: hold right as winner
    step("R9", 1, 0, 14'h0123, 1, 1, 0, 14'h0123, 1, 1);
    // R8: address match ends
    step("R8", 1, 0, 14'h0124, 1, 1, 0, 14'h0123, 1, 1);
    // R2: left standing at 0124, right moves onto it -> right busy
    step("R2", 1, 0, 14'h0124, 0, 1, 0, 14'h0124, 1, 1);
    // R1: different addresses
    step("R1", 1, 0, 14'h3FFF, 1, 1, 0, 14'h0000, 1, 1);
    // R5: same collision pattern with reversed directions, left still standing
    step("R5", 1, 0, 14'h3FFF, 0, 1, 0, 14'h3FFF, 0, 1);
    step("R5", 1, 1, 14'h3FFF, 0, 1, 1, 14'h3FFF, 0, 1);
    step("R5", 1, 0, 14'h3FFF, 1, 1, 1, 14'h3FFF, 0, 1);
    step("R5", 1, 0, 14'h3FFF, 1, 1, 0, 14'h3FFF, 1, 1);
    // R7: slave, collision ignored, busy inputs drive inhibit
    step("R7", 0, 0, 14'h0005, 1, 0, 0, 14'h0005, 1, 1);
    step("R7", 0, 0, 14'h0005, 1, 1, 0, 14'h0005, 1, 0);
    step("R7", 0, 1, 14'h0005, 1, 1, 1, 14'h0006, 1, 1);
    // R10: idle master passes writes straight through
    step("R10", 1, 0, 14'h0001, 1, 0, 0, 14'h0002, 1, 0);

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      logic mm;
      mm = ($urandom % 8) != 0;
      step("R2", mm, ($urandom % 4) == 0, 14'($urandom % 3), 1'($urandom), 1'($urandom),
           ($urandom % 4) == 0, 14'($urandom % 3), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule